// File: doc/BRIEF.md
# Address Watchpoint Match Unit

This block watches the access stream of a processor's load/store and fetch path for up to four programmed addresses. Each of the four watch slots holds an address, and a shared 32-bit control word gives every slot a pair of enable flags and a 4-bit descriptor. The descriptor selects which kind of access the slot reacts to and how many bytes around the address it covers. On every valid access, all enabled slots compare the access address, size and kind in parallel. Each slot that matches sets its sticky bit in a status word, and the unit raises a one-cycle trap pulse.

Software programs the slots through a small register port. Writes are synchronous; reads are combinational from the selected register. A debug handler reads the status word to see which slot fired, then writes zeros to clear the bits it has handled. Bits it writes as one are left unchanged.

Top module: `watch_match_unit`

## Requirements
- R1: After reset every slot address, the control word and the status word read as zero, and trap is low.
- R2: Control bits 15:10 always read as zero, and values written to them are discarded. Control bits 8 and 9 hold what was written and read it back, but they do not change any match result.
- R3: Slot i is enabled when control bit 2i (local) or control bit 2i+1 (global) is set; either one alone is enough. A slot with both bits clear never matches.
- R4: The descriptor of slot i sits at control bits 16+4i to 19+4i. Its two low bits give the access kind and its two high bits give the region length.
- R5: Access kind code 00 (execute) matches only accesses with acc_kind 00 (fetch) whose address equals the slot address exactly. It ignores data accesses and fetches at any other address.
- R6: Access kind code 01 matches only writes (acc_kind 10). Access kind code 11 matches reads (acc_kind 01) and writes. Neither matches fetches. acc_kind 11 is an idle cycle and matches no slot.
- R7: Access kind code 10 is unsupported, and a slot that carries it never matches.
- R8: A data slot covers the naturally aligned region of 1, 2 or 4 bytes (length codes 00, 01, 11) that contains the slot address; the slot address bits below the length are ignored. The slot matches when any byte of the access overlaps that region. The access size acc_size encodes 00=1, 01=2, 10=4 and 11=8 bytes, starting at acc_addr.
- R9: Length code 10 means an 8-byte region. It is honoured only when the WIDE_LEN parameter is 1; with WIDE_LEN=0, which is the default, a data slot with that code never matches.
- R10: A match sets status bit i. Status bits stay set until a write to the status register with a zero in that bit position. Status bits written as one are kept. A match in the same cycle as a clearing write leaves the bit set.
- R11: trap is high for exactly the one cycle after each access that matches at least one slot. Several slots can match the same access; their status bits all set, and only one trap pulse is produced.
- R12: The register selects are: 0 to 3 for the slot addresses, 4 for control, 5 for status. Selects 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | Access size code |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 idle |
| trap | output | 1 | One-cycle debug trap pulse |

## Verification
The vector table sets up each access kind in its own slot, together with region lengths of 1, 2 and 4 bytes. The execute slot is given an address that is not aligned. A data slot is given an address that is not aligned, so that a hit shows the low address bits are ignored. Accesses are chosen to fall exactly on a region's first or last byte, or one byte outside it, and multi-byte accesses are chosen that straddle a region edge. Together these tell the overlap test apart from a plain equality compare. Each access kind is also sent to slots that must reject it, which separates a slot that decodes the kind from one that matches on any access. Directed cases then test one rule each: vacant slots, the unsupported kind code, the 8-byte length code with wide mode off, several slots hit by one access, and a status clear in the same cycle as a hit.

// File: rtl/wmu_pkg.sv
package wmu_pkg;

    localparam int NUM_SLOTS  = 4;
    localparam int CTRL_W     = 32;
    localparam int FIELD_BASE = 16;
    localparam int FIELD_W    = 4;
    localparam int EN_W       = 2;
    localparam int REG_SEL_W  = 3;

    localparam logic [CTRL_W-1:0]    RSVD_MASK = 32'h0000_FC00;
    localparam logic [REG_SEL_W-1:0] REG_CTRL  = 3'd4;
    localparam logic [REG_SEL_W-1:0] REG_STAT  = 3'd5;

    // kind of bus access presented to the unit
    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IDLE  = 2'b11
    } acc_kind_e;

    // slot descriptor, kind part (low two bits)
    typedef enum logic [1:0] {
        RW_EXEC = 2'b00,
        RW_WR   = 2'b01,
        RW_IO   = 2'b10,
        RW_RDWR = 2'b11
    } slot_rw_e;

    // slot descriptor, length part (high two bits); non-binary ordering
    typedef enum logic [1:0] {
        LEN_1 = 2'b00,
        LEN_2 = 2'b01,
        LEN_8 = 2'b10,
        LEN_4 = 2'b11
    } slot_len_e;

    typedef struct packed {
        slot_len_e len;
        slot_rw_e  rw;
    } slot_field_t;

endpackage

// File: rtl/wmu_slot_cmp.sv
module wmu_slot_cmp
    import wmu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit WIDE_LEN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic              slot_en,
    input  logic [3:0]        slot_field,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    output logic              hit
);

    localparam int EXT_W = ADDR_W + 1;

    slot_field_t       fld;
    acc_kind_e         kind;
    logic [EXT_W-1:0]  region_bytes;
    logic [EXT_W-1:0]  access_bytes;
    logic [ADDR_W-1:0] region_mask;
    logic [EXT_W-1:0]  region_first;
    logic [EXT_W-1:0]  region_last;
    logic [EXT_W-1:0]  acc_first;
    logic [EXT_W-1:0]  acc_last;
    logic              len_ok;
    logic              kind_ok;
    logic              overlap;
    logic              exec_hit;
    logic              data_hit;

    always_comb begin
        fld  = slot_field_t'(slot_field);
        kind = acc_kind_e'(acc_kind);

        len_ok = 1'b1;
        unique case (fld.len)
            LEN_1:   region_bytes = EXT_W'(1);
            LEN_2:   region_bytes = EXT_W'(2);
            LEN_4:   region_bytes = EXT_W'(4);
            default: begin
                region_bytes = EXT_W'(8);
                len_ok       = WIDE_LEN;
            end
        endcase

        access_bytes = EXT_W'(1) << acc_size;

        region_mask  = ADDR_W'(region_bytes - EXT_W'(1));
        region_first = {1'b0, slot_addr & ~region_mask};
        region_last  = region_first + region_bytes - EXT_W'(1);
        acc_first    = {1'b0, acc_addr};
        acc_last     = acc_first + access_bytes - EXT_W'(1);
        overlap      = (acc_first <= region_last) && (acc_last >= region_first);

        unique case (fld.rw)
            RW_WR:   kind_ok = (kind == ACC_WRITE);
            RW_RDWR: kind_ok = (kind == ACC_WRITE) || (kind == ACC_READ);
            default: kind_ok = 1'b0;
        endcase

        exec_hit = (fld.rw == RW_EXEC) && (kind == ACC_FETCH) && (acc_addr == slot_addr);
        data_hit = len_ok && kind_ok && overlap;
        hit      = acc_valid && slot_en && (exec_hit || data_hit);
    end

    AST_VACANT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |-> !hit); // R3
    AST_FETCH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && fld.rw == RW_EXEC) |-> (acc_kind == 2'b00 && acc_addr == slot_addr)); // R5
    AST_IO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fld.rw == RW_IO) |-> !hit); // R7
    AST_NARROW_NO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!WIDE_LEN && fld.len == LEN_8 && fld.rw != RW_EXEC) |-> !hit); // R9

endmodule

// File: rtl/wmu_regs.sv
module wmu_regs
    import wmu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [REG_SEL_W-1:0]              reg_sel,
    input  logic [CTRL_W-1:0]                 reg_wdata,
    output logic [CTRL_W-1:0]                 reg_rdata,
    input  logic [NUM_SLOTS-1:0]              hits,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr_o,
    output logic [CTRL_W-1:0]                 ctrl_o,
    output logic                              trap_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr;
        logic [CTRL_W-1:0]                ctrl;
        logic [NUM_SLOTS-1:0]             status;
        logic                             trap;
    } state_t;

    state_t st_d, st_q;
    logic   wr_slot, wr_ctrl, wr_stat;
    logic [NUM_SLOTS-1:0] keep_mask;

    always_comb begin
        st_d    = st_q;
        wr_slot = reg_wr && (int'(reg_sel) < NUM_SLOTS);
        wr_ctrl = reg_wr && (reg_sel == REG_CTRL);
        wr_stat = reg_wr && (reg_sel == REG_STAT);

        if (wr_slot) begin
            st_d.addr[reg_sel[1:0]] = ADDR_W'(reg_wdata);
        end
        if (wr_ctrl) begin
            st_d.ctrl = reg_wdata & ~RSVD_MASK;
        end

        keep_mask   = wr_stat ? reg_wdata[NUM_SLOTS-1:0] : '1;
        st_d.status = (st_q.status & keep_mask) | hits;
        st_d.trap   = |hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_sel) < NUM_SLOTS) begin
            reg_rdata = CTRL_W'(st_q.addr[reg_sel[1:0]]);
        end else if (reg_sel == REG_CTRL) begin
            reg_rdata = st_q.ctrl;
        end else if (reg_sel == REG_STAT) begin
            reg_rdata = CTRL_W'(st_q.status);
        end
    end

    assign slot_addr_o = st_q.addr;
    assign ctrl_o      = st_q.ctrl;
    assign trap_o      = st_q.trap;

    AST_CTRL_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_CTRL) |=> ((ctrl_o & RSVD_MASK) == '0)); // R2
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == REG_STAT) |=> (($past(st_q.status) & ~st_q.status) == '0)); // R10
    AST_TRAP_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (st_q.status != '0)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel > REG_STAT) |-> (reg_rdata == '0)); // R12

endmodule

// File: rtl/watch_match_unit.sv
module watch_match_unit
    import wmu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit WIDE_LEN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    output logic              trap
);

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [CTRL_W-1:0]                ctrl;
    logic [NUM_SLOTS-1:0]             hits;

    wmu_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .hits        (hits),
        .slot_addr_o (slot_addr),
        .ctrl_o      (ctrl),
        .trap_o      (trap)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        wmu_slot_cmp #(
            .ADDR_W   (ADDR_W),
            .WIDE_LEN (WIDE_LEN)
        ) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_addr  (slot_addr[i]),
            .slot_en    (|ctrl[EN_W*i +: EN_W]),
            .slot_field (ctrl[FIELD_BASE + FIELD_W*i +: FIELD_W]),
            .acc_valid  (acc_valid),
            .acc_addr   (acc_addr),
            .acc_size   (acc_size),
            .acc_kind   (acc_kind),
            .hit        (hits[i])
        );
    end

endmodule

// File: tb/watch_match_unit_tb.sv
module watch_match_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'd0;
    logic [1:0]  acc_size = 2'd0;
    logic [1:0]  acc_kind = 2'd3;
    logic        trap;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    watch_match_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_kind  (acc_kind),
        .trap      (trap)
    );

    // kinds: 0 fetch, 1 read, 2 write, 3 idle; sizes: 0=1B 1=2B 2=4B 3=8B
    // {kind, size, addr, expected status}
    localparam int NV = 19;
    localparam logic [39:0] VEC [NV] = '{
        {2'd2, 2'd0, 32'h0000_0100, 4'h1},  // R8 low edge, unaligned slot addr
        {2'd2, 2'd0, 32'h0000_0103, 4'h1},  // R8 high edge
        {2'd1, 2'd2, 32'h0000_0100, 4'h0},  // R6 read vs write-only
        {2'd2, 2'd0, 32'h0000_0104, 4'h0},  // R8 one past
        {2'd2, 2'd2, 32'h0000_00FE, 4'h1},  // R8 straddle
        {2'd2, 2'd0, 32'h0000_00FF, 4'h0},  // R8 one before
        {2'd1, 2'd0, 32'h0000_0203, 4'h2},  // R6 read/write kind, read
        {2'd2, 2'd1, 32'h0000_0202, 4'h2},  // R6 write covering byte
        {2'd1, 2'd0, 32'h0000_0202, 4'h0},  // R8 1-byte region
        {2'd0, 2'd0, 32'h0000_4002, 4'h4},  // R5 exact fetch
        {2'd0, 2'd0, 32'h0000_4000, 4'h0},  // R5 fetch not exact
        {2'd1, 2'd0, 32'h0000_4002, 4'h0},  // R5 read on exec slot
        {2'd0, 2'd0, 32'h0000_0102, 4'h0},  // R6 fetch on data slot
        {2'd1, 2'd0, 32'h0000_0300, 4'h8},  // R3 global enable only, R4 slot 3 field
        {2'd2, 2'd0, 32'h0000_0302, 4'h0},  // R8 2-byte region end
        {2'd2, 2'd3, 32'h0000_0100, 4'h1},  // R8 8-byte access
        {2'd2, 2'd3, 32'h0000_00F8, 4'h0},  // R8 8-byte access below
        {2'd3, 2'd0, 32'h0000_0102, 4'h0},  // R6 idle kind
        {2'd2, 2'd3, 32'h0000_02FC, 4'h8}   // R8 straddle 2-byte region
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // one-cycle access; returns at the negedge after the registering edge
    task automatic access(input logic [1:0] kind, input logic [1:0] size, input logic [31:0] addr);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = kind; acc_size = size; acc_addr = addr;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'd3;
    endtask

    task automatic probe(input string tag, input logic [3:0] exp);
        access(VEC[0][39:38], VEC[0][37:36], VEC[0][35:4]);
    endtask

    task automatic hit_chk(input string tag, input logic [1:0] kind, input logic [1:0] size,
                           input logic [31:0] addr, input logic [3:0] exp);
        wr_reg(3'd5, 32'd0);
        access(kind, size, addr);
        chk(tag, {31'd0, trap}, {31'd0, exp != 4'h0});
        rd_chk(tag, 3'd5, {28'd0, exp});
        @(negedge clk);
        chk(tag, {31'd0, trap}, 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 6; i++) rd_chk("R1 reset register", 3'(i), 32'd0);
        chk("R1 reset trap", {31'd0, trap}, 32'd0);

        // slot setup
        wr_reg(3'd0, 32'h0000_0102);
        wr_reg(3'd1, 32'h0000_0203);
        wr_reg(3'd2, 32'h0000_4002);
        wr_reg(3'd3, 32'h0000_0301);
        wr_reg(3'd4, 32'h703D_FD95);
        rd_chk("R2 reserved bits read zero", 3'd4, 32'h703D_0195);
        rd_chk("R12 slot address readback", 3'd2, 32'h0000_4002);

        // table walk (R4 R5 R6 R8)
        for (int v = 0; v < NV; v++) begin
            hit_chk($sformatf("R8 vector %0d", v), VEC[v][39:38], VEC[v][37:36],
                    VEC[v][35:4], VEC[v][3:0]);
        end

        // R2 slowdown bits have no effect
        wr_reg(3'd4, 32'h703D_0095);
        hit_chk("R2 slowdown clear same match", 2'd2, 2'd0, 32'h0000_0101, 4'h1);
        wr_reg(3'd4, 32'h703D_0395);
        hit_chk("R2 slowdown set same match", 2'd2, 2'd0, 32'h0000_0101, 4'h1);

        // R3 vacant slot 1
        wr_reg(3'd4, 32'h703D_0191);
        hit_chk("R3 vacant slot", 2'd1, 2'd0, 32'h0000_0203, 4'h0);
        // R3 global enable alone on slot 1
        wr_reg(3'd4, 32'h703D_0199);
        hit_chk("R3 global enable", 2'd1, 2'd0, 32'h0000_0203, 4'h2);

        // R7 I/O kind code on slot 1
        wr_reg(3'd4, 32'h702D_0195);
        hit_chk("R7 io kind read", 2'd1, 2'd0, 32'h0000_0203, 4'h0);
        hit_chk("R7 io kind write", 2'd2, 2'd0, 32'h0000_0203, 4'h0);

        // R9 8-byte length code, narrow mode
        wr_reg(3'd4, 32'h70BD_0195);
        hit_chk("R9 wide code ignored", 2'd2, 2'd0, 32'h0000_0203, 4'h0);
        hit_chk("R9 wide code ignored base", 2'd2, 2'd0, 32'h0000_0200, 4'h0);

        // R11 several slots on one access
        wr_reg(3'd4, 32'h703D_0195);
        wr_reg(3'd1, 32'h0000_0101);
        hit_chk("R11 multi-slot hit", 2'd2, 2'd0, 32'h0000_0101, 4'h3);

        // R10 sticky behaviour
        access(2'd2, 2'd0, 32'h0000_0101);
        access(2'd2, 2'd0, 32'h0000_0500);
        rd_chk("R10 sticky after miss", 3'd5, 32'h3);
        wr_reg(3'd5, 32'h0000_0002);
        rd_chk("R10 partial clear", 3'd5, 32'h2);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'd5; reg_wdata = 32'd0;
        acc_valid = 1'b1; acc_kind = 2'd2; acc_size = 2'd0; acc_addr = 32'h0000_0100;
        @(negedge clk);
        reg_wr = 1'b0; acc_valid = 1'b0; acc_kind = 2'd3;
        rd_chk("R10 hit beats clear", 3'd5, 32'h1);
        wr_reg(3'd5, 32'd0);
        rd_chk("R10 full clear", 3'd5, 32'h0);

        // R12 unmapped selects
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped reads zero", 3'd6, 32'd0);
        rd_chk("R12 unmapped read 7", 3'd7, 32'd0);
        rd_chk("R12 control untouched", 3'd4, 32'h703D_0195);
        rd_chk("R12 status untouched", 3'd5, 32'd0);
        rd_chk("R12 slot untouched", 3'd0, 32'h0000_0102);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule